// File: doc/BRIEF.md
# Byte-Sliced Pipelined Adder

This block adds two unsigned 32-bit words and returns a 33-bit result: the 32-bit sum and the carry out of the top bit. It is built as a four-stage pipeline so that a new operand pair can enter on every clock. In the first stage both operands are cut into four 8-bit lanes. The four lane additions run side by side, and each lane keeps a 9-bit partial result whose top bit is that lane's own carry.

Each of the next three stages resolves one more lane, starting from the lowest. The stage adds the settled carry of the lane below to its lane. Any carry this increment produces is ORed into that lane's own carry. When the top lane has been resolved, its carry becomes the 33rd result bit.

Every stage owns one token and has its own valid/ready pair, so up to four operand pairs can be in flight at once. The upstream side is a valid/ready input and the downstream side is a registered valid/ready output. Back-pressure from the output stalls the pipeline without losing or reordering results.

Top module: `byte_sliced_adder`

## Requirements
- R1: For every accepted pair (a, b), the output word {out_carry, out_sum} equals the 33-bit unsigned value a + b. out_carry is bit 32 and out_sum is bits 31..0.
- R2: With out_ready held high, a pair accepted at a clock edge shows up with out_valid high four clock edges later.
- R3: Results leave in the same order as their operand pairs were accepted. None is dropped and none is duplicated.
- R4: While out_valid is high and out_ready is low, out_valid stays high and out_sum and out_carry hold their values at the next edge.
- R5: When out_ready is held low, the block accepts exactly four pairs and then drives in_ready low. in_ready is low only while out_valid is high.
- R6: While out_ready is high, in_ready is high, so the block sustains one result per cycle.
- R7: A synchronous active-high reset empties the pipeline: out_valid is low and in_ready is high in the cycle after reset.
- R8: A carry produced in the lowest lane ripples through all higher lanes. For example, 0xFFFFFFFF + 0x00000001 gives sum 0 with out_carry 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair is offered |
| in_ready | output | 1 | Block takes the offered pair at this edge |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result at this edge |
| out_sum | output | 32 | Low 32 bits of the sum |
| out_carry | output | 1 | Carry out of bit 31 |

## Verification
Suppose a lane carry is folded into the wrong lane, or is lost in a middle stage. The first result that depends on that carry then differs from a + b, four edges after its pair was accepted. Suppose instead that a stage register mishandles a stall. The fault then shows at the ports as a dropped, duplicated or reordered result, or as a value that changes while out_ready is low. The reference queue catches it on the next output handshake. A wrong ready chain shows up in the same cycle, either as in_ready falling while out_ready is high or as a fifth pair being taken into a full pipeline.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
    parameter int unsigned LANE_W = 8;
    parameter int unsigned LANES  = 4;
    localparam int unsigned WORD_W = LANE_W * LANES;
    localparam int unsigned PART_W = LANE_W + 1;
    localparam int unsigned TOK_W  = PART_W * LANES;

    // one lane: bit LANE_W is the lane carry, the rest the lane sum
    typedef logic [PART_W-1:0] lane_t;

    typedef struct packed {
        lane_t [LANES-1:0] lane;
    } token_t;

    function automatic lane_t lane_add(input logic [LANE_W-1:0] x,
                                       input logic [LANE_W-1:0] y);
        return {1'b0, x} + {1'b0, y};
    endfunction

    // add the settled carry from below; merge any new carry with the lane's own
    function automatic lane_t lane_fold(input lane_t cur, input logic cin);
        lane_t t;
        t = {1'b0, cur[LANE_W-1:0]} + {{LANE_W{1'b0}}, cin};
        return {cur[LANE_W] | t[LANE_W], t[LANE_W-1:0]};
    endfunction
endpackage

// File: rtl/bsa_stage.sv
module bsa_stage #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         up_valid,
    output logic         up_ready,
    input  logic [W-1:0] up_data,
    output logic         dn_valid,
    input  logic         dn_ready,
    output logic [W-1:0] dn_data
);
    logic         valid_q;
    logic [W-1:0] data_q;

    // room when empty or when the held token leaves this cycle
    assign up_ready = !valid_q || dn_ready;
    assign dn_valid = valid_q;
    assign dn_data  = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
        end else if (up_ready) begin
            valid_q <= up_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (up_ready && up_valid) begin
            data_q <= up_data;
        end
    end

    // R4
    stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));
endmodule

// File: rtl/bsa_split.sv
module bsa_split
    import bsa_pkg::*;
(
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic [TOK_W-1:0]  tok
);
    token_t t;

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            assign t.lane[k] = lane_add(a[k*LANE_W +: LANE_W], b[k*LANE_W +: LANE_W]);
        end
    endgenerate

    assign tok = t;
endmodule

// File: rtl/bsa_fold.sv
module bsa_fold
    import bsa_pkg::*;
#(
    parameter int unsigned IDX = 1
) (
    input  logic [TOK_W-1:0] tok_in,
    output logic [TOK_W-1:0] tok_out
);
    token_t ti, to;

    always_comb begin
        ti = tok_in;
        to = ti;
        // the lane below was settled in an earlier stage
        to.lane[IDX] = lane_fold(ti.lane[IDX], ti.lane[IDX-1][LANE_W]);
    end

    assign tok_out = to;
endmodule

// File: rtl/byte_sliced_adder.sv
module byte_sliced_adder
    import bsa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_a,
    input  logic [WORD_W-1:0] in_b,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_sum,
    output logic              out_carry
);
    logic [TOK_W-1:0] tok_d [LANES];
    logic [TOK_W-1:0] tok_q [LANES];
    logic             vld   [LANES];
    logic             rdy   [LANES];
    logic             rdy_dn[LANES];

    bsa_split u_split (.a(in_a), .b(in_b), .tok(tok_d[0]));

    generate
        for (genvar s = 1; s < LANES; s++) begin : g_fold
            bsa_fold #(.IDX(s)) u_fold (.tok_in(tok_q[s-1]), .tok_out(tok_d[s]));
        end

        for (genvar s = 0; s < LANES; s++) begin : g_stage
            if (s == LANES - 1) begin : g_last
                assign rdy_dn[s] = out_ready;
            end else begin : g_mid
                assign rdy_dn[s] = rdy[s+1];
            end

            if (s == 0) begin : g_first
                bsa_stage #(.W(TOK_W)) u_stage (
                    .clk(clk), .rst(rst),
                    .up_valid(in_valid), .up_ready(rdy[s]), .up_data(tok_d[s]),
                    .dn_valid(vld[s]), .dn_ready(rdy_dn[s]), .dn_data(tok_q[s]));
            end else begin : g_rest
                bsa_stage #(.W(TOK_W)) u_stage (
                    .clk(clk), .rst(rst),
                    .up_valid(vld[s-1]), .up_ready(rdy[s]), .up_data(tok_d[s]),
                    .dn_valid(vld[s]), .dn_ready(rdy_dn[s]), .dn_data(tok_q[s]));
            end
        end
    endgenerate

    token_t fin;
    assign fin = tok_q[LANES-1];

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_out
            assign out_sum[k*LANE_W +: LANE_W] = fin.lane[k][LANE_W-1:0];
        end
    endgenerate

    assign out_carry = fin.lane[LANES-1][LANE_W];
    assign out_valid = vld[LANES-1];
    assign in_ready  = rdy[0];

    // R4
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) && $stable(out_carry)));

    // R6
    flow_ready_chk: assert property (@(posedge clk) disable iff (rst)
        out_ready |-> in_ready);

    // R5
    full_only_chk: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> out_valid);

    // R7
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ready));
endmodule

// File: tb/tb_byte_sliced_adder.sv
module tb_byte_sliced_adder;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_a, in_b;
    logic        out_valid;
    logic        out_ready;
    logic [31:0] out_sum;
    logic        out_carry;

    always #2 clk = ~clk;

    byte_sliced_adder dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
        .out_sum(out_sum), .out_carry(out_carry));

    int errors = 0;
    int checks = 0;
    int cycle  = 0;
    logic [32:0] exp_q[$];
    int          acc_q[$];
    bit          lat_mode = 0;
    bit          prev_stall = 0;
    logic [32:0] prev_word;

    task automatic check(input bit ok, input string req, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cycle);
        end
    endtask

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Called after inputs settle: record handshakes that will occur at the next edge.
    task automatic observe();
        logic [32:0] w;
        logic [32:0] e;
        int a;
        w = {out_carry, out_sum};
        if (prev_stall) begin
            check(out_valid && w == prev_word, "R4 hold", {out_valid, w[31:0]}, {1'b1, prev_word[31:0]});
        end
        if (out_ready) check(in_ready, "R6 ready", {32'd0, in_ready}, 33'd1);
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(0, "R3 extra", w, 33'd0);
            end else begin
                e = exp_q.pop_front();
                a = acc_q.pop_front();
                check(w == e, "R1/R3 sum", w, e);
                if (lat_mode) check(cycle - a == 4, "R2 latency", 33'(cycle - a), 33'd4);
            end
        end
        if (in_valid && in_ready) begin
            exp_q.push_back({1'b0, in_a} + {1'b0, in_b});
            acc_q.push_back(cycle);
        end
        prev_stall = out_valid && !out_ready;
        prev_word  = w;
    endtask

    task automatic step(input bit v, input logic [31:0] a, input logic [31:0] b, input bit r);
        @(negedge clk);
        cycle++;
        in_valid = v; in_a = a; in_b = b; out_ready = r;
        #0.5;
        observe();
    endtask

    task automatic drain();
        for (int i = 0; i < 40 && exp_q.size() != 0; i++) step(0, 0, 0, 1);
        check(exp_q.size() == 0, "R3 drained", 33'(exp_q.size()), 33'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        rst = 1; in_valid = 0; in_a = 0; in_b = 0; out_ready = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk); #0.5;
        // R7
        check(!out_valid && in_ready, "R7 reset", {31'd0, out_valid, in_ready}, 33'd1);

        // R2 and R8: directed vectors streamed back to back
        lat_mode = 1;
        step(1, 32'hFFFFFFFF, 32'h00000001, 1); // R8 full ripple
        step(1, 32'h00000000, 32'h00000000, 1);
        step(1, 32'h00FF00FF, 32'h00010001, 1);
        step(1, 32'h80000000, 32'h80000000, 1);
        step(1, 32'hFFFFFFFF, 32'hFFFFFFFF, 1);
        step(1, 32'h0000FFFF, 32'h00000001, 1);
        for (int i = 0; i < 150; i++) step(1, $urandom, $urandom, 1);
        drain();
        lat_mode = 0;

        // R5: out_ready low, pipeline fills with exactly four
        begin
            int acc = 0;
            for (int i = 0; i < 10; i++) begin
                step(1, $urandom, $urandom, 0);
                if (in_valid && in_ready) acc++;
            end
            check(acc == 4, "R5 fill count", 33'(acc), 33'd4);
            check(!in_ready, "R5 in_ready", {32'd0, in_ready}, 33'd0);
        end
        drain();

        // R3/R4: random valid and ready gaps
        for (int i = 0; i < 600; i++) begin
            logic [31:0] ra;
            ra = $urandom;
            if (ra[3:0] == 0) ra = 32'hFFFFFFFF;
            step(($urandom % 3) != 0, ra, $urandom, ($urandom % 2) == 0);
        end
        drain();

        finish_up();
    end
endmodule